// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block collects reset requests from three kinds of source and turns them into one ordered reset sequence. The sources are a PLL lock-loss request, a clock-failure request from a clock monitor, and a watchdog request. A clock-failure request only counts when its enable input is high. A watchdog time-out and a debug reset command share one path and are handled the same way. Once a request is accepted, an internal reset and an external reset-out line go high together. At that same moment the wakeup-configuration and PLL-reference inputs are latched.

Release happens in stages. The block waits until no accepted request is active. It then counts a configurable number of cycles, latches the two boot-configuration inputs, and drops the internal reset. Four cycles after that it drops reset-out. At that same edge, a status register records which source caused the reset, with one bit per source.

The status register keeps its value through the next sequence. Only the power-on reset clears it. Software reads it through a one-cycle read port.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While `por` is high at a clock edge, `int_rst`, `rst_out`, `wkp_cfg`, `pllref_cfg`, `boot_cfg` and `rd_data` all go to 0, and the status register goes to its power-on value (all zero by default).
- R2: At the first clock edge where an accepted request is high, `int_rst` and `rst_out` both become 1 at that edge.
- R3: When `loc_rst_en` is 0, a `loc_req` pulse on its own leaves `rst_out` at 0 and leaves the status register unchanged.
- R4: `wkp_cfg` and `pllref_cfg` take the values that `wkp_pin` and `pllref_pin` have at the edge that starts (or restarts) the sequence.
- R5: The delay phase starts at the first edge where no accepted request is high. At the DLY_CYC-th edge after that, `boot_cfg` latches `boot_pin` and `int_rst` falls.
- R6: `rst_out` falls exactly four clock edges after the edge that latched `boot_cfg`.
- R7: At the edge where `rst_out` falls, exactly one status bit is set and the others are cleared. Bit 0 means lock loss, bit 1 means clock failure and bit 2 means watchdog/debug. `rd_data` holds the status zero-extended in its low bits.
- R8: `wdt_req` and `dbg_req` have identical effects on timing, and both set status bit 2.
- R9: For a watchdog/debug reset, the delay does not start while `lol_req` is still high, even if `lol_req` rose after the sequence began.
- R10: An accepted request during the delay or settle phase restarts the sequence. `int_rst` goes high again, the source is re-evaluated, and the configuration values are re-captured.
- R11: If several requests are high at the start edge, the recorded source follows this priority: clock failure first, then lock loss, then watchdog/debug.
- R12: `rd_data` shows the status one cycle after `rd_en` is high, and 0 otherwise. During a sequence it still returns the status of the previous reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Synchronous active-high power-on reset |
| lol_req | input | 1 | PLL lock-loss reset request |
| loc_req | input | 1 | Clock-failure reset request from the monitor |
| loc_rst_en | input | 1 | Enables clock-failure requests to start a reset |
| wdt_req | input | 1 | Watchdog time-out reset request |
| dbg_req | input | 1 | Debug reset command |
| wkp_pin | input | 1 | Wakeup-configuration input |
| pllref_pin | input | 1 | PLL reference selection input |
| boot_pin | input | BOOT_W | Boot-configuration inputs |
| rd_en | input | 1 | Status read strobe |
| int_rst | output | 1 | Internal reset |
| rst_out | output | 1 | External reset-out |
| wkp_cfg | output | 1 | Latched wakeup configuration |
| pllref_cfg | output | 1 | Latched PLL reference selection |
| boot_cfg | output | BOOT_W | Latched boot configuration |
| rd_data | output | DATA_W | Status read data |

## Verification
A wrong phase counter shows up at the ports as a high time of `rst_out` or `int_rst` that is off from the arithmetic value. That error is visible within one sequence, about DLY_CYC plus six cycles after the last request drops. A wrong capture point shows up as a latched configuration value that does not match the one pin value the bench makes distinct in the capture cycle. A wrong cause or priority register only shows at the release edge, so the bench reads the status right after each sequence, and also mid-sequence to confirm the old value is kept.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_HOLD, ST_DELAY, ST_SETTLE} seq_st_e;
  typedef enum logic [1:0] {SRC_LOL = 2'd0, SRC_LOC = 2'd1, SRC_WDG = 2'd2} src_e;
  localparam int NUM_SRC    = 3;
  localparam int SETTLE_CYC = 4;
endpackage

// File: rtl/rsc_req_arb.sv
module rsc_req_arb
  import rsc_pkg::*;
(
  input  logic lol_req,
  input  logic loc_req,
  input  logic loc_rst_en,
  input  logic wdt_req,
  input  logic dbg_req,
  output logic accept,
  output src_e top_src
);
  logic loc_ok;
  logic wdg_any;

  always_comb begin
    loc_ok  = loc_req & loc_rst_en;
    wdg_any = wdt_req | dbg_req;
    accept  = loc_ok | lol_req | wdg_any;
    if (loc_ok)       top_src = SRC_LOC;
    else if (lol_req) top_src = SRC_LOL;
    else              top_src = SRC_WDG;
  end
endmodule

// File: rtl/rsc_seq_fsm.sv
module rsc_seq_fsm
  import rsc_pkg::*;
#(
  parameter int DLY_CYC = 16,
  parameter int BOOT_W  = 2
) (
  input  logic              clk,
  input  logic              por,
  input  logic              accept,
  input  src_e              top_src,
  input  logic              wkp_pin,
  input  logic              pllref_pin,
  input  logic [BOOT_W-1:0] boot_pin,
  output logic              int_rst,
  output logic              rst_out,
  output logic              wkp_cfg,
  output logic              pllref_cfg,
  output logic [BOOT_W-1:0] boot_cfg,
  output src_e              cause,
  output logic              release_p
);
  localparam int MAX_CNT = (DLY_CYC > SETTLE_CYC) ? DLY_CYC : SETTLE_CYC;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);
  localparam logic [CNT_W-1:0] DLY_LAST = CNT_W'(DLY_CYC - 1);
  localparam logic [CNT_W-1:0] SET_LAST = CNT_W'(SETTLE_CYC - 1);

  seq_st_e          state;
  logic [CNT_W-1:0] cnt;
  logic             start;

  assign start     = accept && (state != ST_HOLD);
  assign release_p = (state == ST_SETTLE) && (cnt == SET_LAST) && !accept;

  always_ff @(posedge clk) begin
    if (por) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      int_rst    <= 1'b0;
      rst_out    <= 1'b0;
      wkp_cfg    <= 1'b0;
      pllref_cfg <= 1'b0;
      boot_cfg   <= '0;
      cause      <= SRC_LOL;
    end else if (start) begin
      state      <= ST_HOLD;
      cnt        <= '0;
      int_rst    <= 1'b1;
      rst_out    <= 1'b1;
      wkp_cfg    <= wkp_pin;
      pllref_cfg <= pllref_pin;
      cause      <= top_src;
    end else begin
      case (state)
        ST_HOLD: begin
          if (!accept) begin
            state <= ST_DELAY;
            cnt   <= '0;
          end
        end
        ST_DELAY: begin
          if (cnt == DLY_LAST) begin
            boot_cfg <= boot_pin;
            int_rst  <= 1'b0;
            state    <= ST_SETTLE;
            cnt      <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_SETTLE: begin
          if (cnt == SET_LAST) begin
            rst_out <= 1'b0;
            state   <= ST_IDLE;
            cnt     <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          cnt <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/rsc_status_reg.sv
module rsc_status_reg
  import rsc_pkg::*;
#(
  parameter int                 DATA_W   = 8,
  parameter logic [NUM_SRC-1:0] POR_STAT = '0
) (
  input  logic              clk,
  input  logic              por,
  input  logic              release_p,
  input  src_e              cause,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data
);
  logic [NUM_SRC-1:0] stat;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (por)            stat[i] <= POR_STAT[i];
      else if (release_p) stat[i] <= (int'(cause) == i);
    end
  end

  always_ff @(posedge clk) begin
    if (por)        rd_data <= '0;
    else if (rd_en) rd_data <= {{(DATA_W-NUM_SRC){1'b0}}, stat};
    else            rd_data <= '0;
  end
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rsc_pkg::*;
#(
  parameter int                 DLY_CYC  = 16,
  parameter int                 BOOT_W   = 2,
  parameter int                 DATA_W   = 8,
  parameter logic [NUM_SRC-1:0] POR_STAT = '0
) (
  input  logic              clk,
  input  logic              por,
  input  logic              lol_req,
  input  logic              loc_req,
  input  logic              loc_rst_en,
  input  logic              wdt_req,
  input  logic              dbg_req,
  input  logic              wkp_pin,
  input  logic              pllref_pin,
  input  logic [BOOT_W-1:0] boot_pin,
  input  logic              rd_en,
  output logic              int_rst,
  output logic              rst_out,
  output logic              wkp_cfg,
  output logic              pllref_cfg,
  output logic [BOOT_W-1:0] boot_cfg,
  output logic [DATA_W-1:0] rd_data
);
  logic accept;
  src_e top_src;
  src_e cause;
  logic release_p;

  rsc_req_arb arb_i (
    .lol_req    (lol_req),
    .loc_req    (loc_req),
    .loc_rst_en (loc_rst_en),
    .wdt_req    (wdt_req),
    .dbg_req    (dbg_req),
    .accept     (accept),
    .top_src    (top_src)
  );

  rsc_seq_fsm #(.DLY_CYC(DLY_CYC), .BOOT_W(BOOT_W)) fsm_i (
    .clk        (clk),
    .por        (por),
    .accept     (accept),
    .top_src    (top_src),
    .wkp_pin    (wkp_pin),
    .pllref_pin (pllref_pin),
    .boot_pin   (boot_pin),
    .int_rst    (int_rst),
    .rst_out    (rst_out),
    .wkp_cfg    (wkp_cfg),
    .pllref_cfg (pllref_cfg),
    .boot_cfg   (boot_cfg),
    .cause      (cause),
    .release_p  (release_p)
  );

  rsc_status_reg #(.DATA_W(DATA_W), .POR_STAT(POR_STAT)) stat_i (
    .clk       (clk),
    .por       (por),
    .release_p (release_p),
    .cause     (cause),
    .rd_en     (rd_en),
    .rd_data   (rd_data)
  );
endmodule

// File: rtl/rst_seq_ctrl_chk.sv
module rst_seq_ctrl_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              por,
  input logic              lol_req,
  input logic              loc_req,
  input logic              loc_rst_en,
  input logic              wdt_req,
  input logic              dbg_req,
  input logic              int_rst,
  input logic              rst_out,
  input logic [DATA_W-1:0] rd_data
);
  logic acc_in;
  assign acc_in = lol_req || wdt_req || dbg_req || (loc_req && loc_rst_en);

  AST_ACCEPT_ASSERTS: assert property (@(posedge clk) disable iff (por)
    acc_in |=> (rst_out && int_rst)); // R2

  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (por)
    (!rst_out && !acc_in) |=> !rst_out); // R3

  AST_INT_INSIDE_OUT: assert property (@(posedge clk) disable iff (por)
    int_rst |-> rst_out); // R5

  AST_SETTLE_FOUR: assert property (@(posedge clk) disable iff (por)
    $fell(rst_out) |-> (!int_rst && !$past(int_rst, 4) && $past(int_rst, 5))); // R6

  AST_STATUS_ONEHOT: assert property (@(posedge clk) disable iff (por)
    $onehot0(rd_data)); // R7
endmodule

bind rst_seq_ctrl rst_seq_ctrl_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/rst_seq_ctrl_tb_top.sv
module rst_seq_ctrl_tb_top;
  localparam int DLY = 5;

  logic       clk = 1'b0;
  logic       por = 1'b1;
  logic       lol_req = 0, loc_req = 0, loc_rst_en = 0, wdt_req = 0, dbg_req = 0;
  logic       wkp_pin = 0, pllref_pin = 0, rd_en = 0;
  logic [1:0] boot_pin = '0;
  logic       int_rst, rst_out, wkp_cfg, pllref_cfg;
  logic [1:0] boot_cfg;
  logic [7:0] rd_data;

  int n_chk = 0, n_fail = 0, ncase = 0, cyc = 0;
  logic [7:0] old_stat = '0;

  always #5 clk = ~clk;

  rst_seq_ctrl #(.DLY_CYC(DLY)) dut_i (
    .clk(clk), .por(por), .lol_req(lol_req), .loc_req(loc_req),
    .loc_rst_en(loc_rst_en), .wdt_req(wdt_req), .dbg_req(dbg_req),
    .wkp_pin(wkp_pin), .pllref_pin(pllref_pin), .boot_pin(boot_pin),
    .rd_en(rd_en), .int_rst(int_rst), .rst_out(rst_out), .wkp_cfg(wkp_cfg),
    .pllref_cfg(pllref_cfg), .boot_cfg(boot_cfg), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 20000);
      finish_run();
    end
  end

  function automatic bit in_w(input int i, input int s, input int e);
    return (i >= s) && (i < e);
  endfunction

  task automatic rd_stat(output logic [7:0] v);
    rd_en = 1'b1;
    @(negedge clk);
    v = rd_data;
    rd_en = 1'b0;
  endtask

  task automatic run_case(input string tag, input int ls, input int le,
                          input int cs, input int ce, input int ws, input int we,
                          input int ds, input int de, input bit en, input int dip);
    int L = -1, st = -1, cz = 0, tot, hi_r = 0, hi_i = 0;
    bit prev = 0;
    bit [1:0] boot_a = 2'(ncase);
    bit pv = ncase[0];
    logic [7:0] v;
    for (int i = 0; i < 64; i++) begin
      bit a;
      a = in_w(i, ls, le) || in_w(i, ws, we) || in_w(i, ds, de) || (en && in_w(i, cs, ce));
      if (a) begin
        L = i;
        if (!prev) begin
          st = i;
          cz = (en && in_w(i, cs, ce)) ? 1 : (in_w(i, ls, le) ? 0 : 2);
        end
      end
      prev = a;
    end
    tot = (L < 0) ? 12 : L + DLY + 7;
    loc_rst_en = en;
    for (int i = 0; i < tot; i++) begin
      lol_req    = in_w(i, ls, le);
      loc_req    = in_w(i, cs, ce);
      wdt_req    = in_w(i, ws, we);
      dbg_req    = in_w(i, ds, de);
      wkp_pin    = (i == st);
      pllref_pin = (i == st) ? pv : !pv;
      boot_pin   = (i == L + 1 + DLY) ? boot_a : ~boot_a;
      rd_en      = (i == 1);
      @(negedge clk);
      if (rst_out) hi_r++;
      if (int_rst) hi_i++;
      if (i == st) chk(rst_out && int_rst, {tag, " R2 assert"}, int'({rst_out, int_rst}), 3);
      if (i == 1) chk(rd_data == old_stat, {tag, " R12 old status"}, int'(rd_data), int'(old_stat));
    end
    {lol_req, loc_req, wdt_req, dbg_req, wkp_pin, pllref_pin, rd_en} = '0;
    if (L < 0) begin
      chk(hi_r == 0, {tag, " R3 no reset"}, hi_r, 0);
      rd_stat(v);
      chk(v == old_stat, {tag, " R3 status kept"}, int'(v), int'(old_stat));
    end else begin
      chk(hi_r == L + DLY + 5, {tag, " R6 rst_out length"}, hi_r, L + DLY + 5);
      chk(hi_i == L + 1 + DLY - dip, {tag, " R5 int_rst length"}, hi_i, L + 1 + DLY - dip);
      chk(boot_cfg == boot_a, {tag, " R5 boot sample"}, int'(boot_cfg), int'(boot_a));
      chk(wkp_cfg == 1'b1, {tag, " R4 wkp capture"}, int'(wkp_cfg), 1);
      chk(pllref_cfg == pv, {tag, " R4 pllref capture"}, int'(pllref_cfg), int'(pv));
      rd_stat(v);
      chk(v == 8'(1 << cz), {tag, " R7 status"}, int'(v), 1 << cz);
      old_stat = v;
    end
    ncase++;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    // R1 power-on state
    chk({int_rst, rst_out, wkp_cfg, pllref_cfg, boot_cfg} == '0, "R1 outputs",
        int'({int_rst, rst_out, wkp_cfg, pllref_cfg, boot_cfg}), 0);
    por = 1'b0;
    rd_stat(v);
    chk(v == 8'h00, "R1 status", int'(v), 0);

    for (int h = 1; h <= 4; h++) begin
      run_case("R2 lol", 0, h, 0, 0, 0, 0, 0, 0, 1'b0, 0);
      run_case("R2 loc", 0, 0, 0, h, 0, 0, 0, 0, 1'b1, 0);
      run_case("R2 wdt", 0, 0, 0, 0, 0, h, 0, 0, 1'b0, 0);
      run_case("R8 dbg", 0, 0, 0, 0, 0, 0, 0, h, 1'b0, 0);
    end
    run_case("R3 loc disabled", 0, 0, 0, 3, 0, 0, 0, 0, 1'b0, 0);
    run_case("R11 all three", 0, 2, 0, 2, 0, 2, 0, 0, 1'b1, 0);
    run_case("R11 lol over wdt", 0, 2, 0, 0, 0, 2, 0, 0, 1'b1, 0);
    run_case("R11 loc over dbg", 0, 0, 0, 1, 0, 0, 0, 3, 1'b1, 0);
    run_case("R9 wdt waits lol", 1, 4, 0, 0, 0, 1, 0, 0, 1'b0, 0);
    run_case("R9 dbg waits lol", 1, 6, 0, 0, 0, 0, 0, 2, 1'b0, 0);
    run_case("R10 restart delay", 0, 0, 0, 0, 0, 2, 4, 5, 1'b0, 0);
    run_case("R10 restart settle", 7, 8, 0, 0, 0, 1, 0, 0, 1'b0, 1);
    run_case("R10 loc restart", 0, 0, 3, 4, 0, 1, 0, 0, 1'b1, 0);
    finish_run();
  end
endmodule